// File: doc/BRIEF.md
# Quasi-Bidirectional Pin Drive One-Shot

This block decides, on every system clock, how the pad of each quasi-bidirectional port pin is driven. For each pin it takes the port latch bit, a mode bit that selects general I/O or a memory-bus function, the value the bus logic wants on the pin in bus mode, and a flag that marks the pin as a read or write strobe. From these it produces three pad enables: strong pull-down, strong pull-up and weak pull-up.

In I/O mode a real 0-to-1 change of the latch bit gives a short burst of strong pull-up so that the pin edge is fast. After the burst only the weak pull-up holds the pin high, so an outside device can still pull it low and the pin can be read as an input. Moving a pin from bus mode to I/O mode never starts the burst. A strobe pin in bus mode gets a shorter burst after each rising strobe edge. Other bus-mode pins follow the bus value with strong drive in both directions. All pins are independent and the pin count and both burst lengths are parameters.

Top module: `pin_drive_oneshot`

## Requirements
- R1: In I/O mode (mode bit 0), a latch change from 0 to 1 with the mode unchanged since the previous cycle turns the strong pull-up on for exactly IO_PULSE cycles (default 2), starting in the first cycle the latch reads 1.
- R2: In I/O mode, once the burst has ended and while the latch stays 1, only the weak pull-up is on (strong pull-up and pull-down off).
- R3: In the first cycle after a pin moves from bus mode (mode bit 1) to I/O mode the strong pull-up is off, even if the pin was low and the latch is 1.
- R4: A pin with the strobe flag set, in bus mode, gets the strong pull-up for exactly STROBE_PULSE cycles (default 1) after its bus value goes from 0 to 1, then weak pull-up only while the bus value stays 1.
- R5: Whenever the driven value (latch in I/O mode, bus value in bus mode) is 0, the strong pull-down is on and both pull-ups are off in that same cycle.
- R6: A pin in bus mode without the strobe flag drives strong pull-up exactly when its bus value is 1, with no burst timing.
- R7: A latch sequence 1, 0, 1 in I/O mode starts a fresh full-length burst at the second 1, whatever was left of the earlier burst.
- R8: During and right after reset, with the latch at 1 in I/O mode, each pin has the weak pull-up only and no burst pending.
- R9: The strong pull-down is never on together with either pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_latch | input | PINS | Port latch bit per pin |
| bus_sel | input | PINS | Mode per pin: 0 general I/O, 1 memory-bus function |
| bus_dout | input | PINS | Value driven by the bus logic in bus mode |
| strobe_flag | input | PINS | Pin serves as read or write strobe |
| pull_down_en | output | PINS | Strong pull-down enable |
| strong_up_en | output | PINS | Strong pull-up enable |
| weak_up_en | output | PINS | Weak pull-up enable |

## Verification
The bench aims at the mode switch from bus to I/O with the pin low and the latch high: a design that treated the value change as a latch edge would fire a burst there. It drives a 1-0-1 latch pattern in the middle of a burst, where a design that kept the old count would end the second burst one cycle early. Strobe pins are driven in both modes so that a design applying the two-cycle length to strobe edges, or none at all, shows a wrong strong pull-up cycle. A long pseudo-random phase mixes latch, bus and mode changes on four pins at once, so a design sharing state between pins or missing the cancel on a mode change differs from the reference.

// File: rtl/pin_drive_pkg.sv
package pin_drive_pkg;

   localparam logic MODE_IO  = 1'b0;
   localparam logic MODE_BUS = 1'b1;

   typedef struct packed {
      logic pd;
      logic spu;
      logic wpu;
   } pad_drive_t;

   function automatic int larger_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pin_edge_track.sv
module pin_edge_track
   import pin_drive_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic val,
   input  logic mode,
   input  logic capable,
   output logic trig,
   output logic same_mode
);

   logic prev_val;
   logic prev_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_val  <= 1'b1;
         prev_mode <= MODE_IO;
      end else begin
         prev_val  <= val;
         prev_mode <= mode;
      end
   end

   assign same_mode = (mode == prev_mode);
   assign trig      = capable & val & ~prev_val & same_mode;

   // R3
   mode_switch_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode)) |-> !trig);

endmodule

// File: rtl/pin_burst_timer.sv
module pin_burst_timer #(
   parameter int IO_PULSE     = 2,
   parameter int STROBE_PULSE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic hold,
   input  logic short_sel,
   output logic active
);
   import pin_drive_pkg::*;

   localparam int MAXP = larger_of(IO_PULSE, STROBE_PULSE);
   localparam int CW   = $clog2(MAXP + 1);
   localparam logic [CW-1:0] IO_LOAD  = CW'(IO_PULSE - 1);
   localparam logic [CW-1:0] STB_LOAD = CW'(STROBE_PULSE - 1);
   localparam logic [CW-1:0] CNT_MAX  = CW'(MAXP - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nxt;

   always_comb begin
      if (trig)
         cnt_nxt = short_sel ? STB_LOAD : IO_LOAD;
      else if (active && hold)
         cnt_nxt = cnt - 1'b1;
      else
         cnt_nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   assign active = (cnt != '0);

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);

   // R1
   count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !trig) |=> (cnt < $past(cnt)));

endmodule

// File: rtl/pin_pad_decode.sv
module pin_pad_decode
   import pin_drive_pkg::*;
(
   input  logic       val,
   input  logic       capable,
   input  logic       trig,
   input  logic       burst_live,
   output pad_drive_t drive
);

   always_comb begin
      drive.pd  = ~val;
      drive.wpu = val;
      drive.spu = capable ? (trig | burst_live) : val;
   end

endmodule

// File: rtl/pin_drive_oneshot.sv
module pin_drive_oneshot #(
   parameter int PINS         = 8,
   parameter int IO_PULSE     = 2,
   parameter int STROBE_PULSE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] port_latch,
   input  logic [PINS-1:0] bus_sel,
   input  logic [PINS-1:0] bus_dout,
   input  logic [PINS-1:0] strobe_flag,
   output logic [PINS-1:0] pull_down_en,
   output logic [PINS-1:0] strong_up_en,
   output logic [PINS-1:0] weak_up_en
);
   import pin_drive_pkg::*;

   if (PINS < 1)         begin : g_bad_pins  $error("PINS must be at least 1");         end
   if (IO_PULSE < 1)     begin : g_bad_io    $error("IO_PULSE must be at least 1");     end
   if (STROBE_PULSE < 1) begin : g_bad_stb   $error("STROBE_PULSE must be at least 1"); end

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      logic       val;
      logic       capable;
      logic       trig;
      logic       same_mode;
      logic       active;
      logic       keep;
      pad_drive_t drive;

      assign val     = (bus_sel[i] == MODE_BUS) ? bus_dout[i] : port_latch[i];
      assign capable = (bus_sel[i] == MODE_IO) | strobe_flag[i];
      assign keep    = val & same_mode & capable;

      pin_edge_track u_edge (
         .clk       (clk),
         .rst_n     (rst_n),
         .val       (val),
         .mode      (bus_sel[i]),
         .capable   (capable),
         .trig      (trig),
         .same_mode (same_mode)
      );

      pin_burst_timer #(
         .IO_PULSE     (IO_PULSE),
         .STROBE_PULSE (STROBE_PULSE)
      ) u_timer (
         .clk       (clk),
         .rst_n     (rst_n),
         .trig      (trig),
         .hold      (keep),
         .short_sel (bus_sel[i] & strobe_flag[i]),
         .active    (active)
      );

      pin_pad_decode u_dec (
         .val        (val),
         .capable    (capable),
         .trig       (trig),
         .burst_live (active & keep),
         .drive      (drive)
      );

      assign pull_down_en[i] = drive.pd;
      assign strong_up_en[i] = drive.spu;
      assign weak_up_en[i]   = drive.wpu;

      // R5
      zero_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((bus_sel[i] ? bus_dout[i] : port_latch[i]) == 1'b0)
            |-> (pull_down_en[i] && !strong_up_en[i] && !weak_up_en[i]));

      // R3
      no_switch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!bus_sel[i] && $past(bus_sel[i])) |-> !strong_up_en[i]);

      // R6
      bus_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel[i] && !strobe_flag[i]) |-> (strong_up_en[i] == bus_dout[i]));

      // R9
      drive_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(pull_down_en[i] && (strong_up_en[i] || weak_up_en[i])));

      if (STROBE_PULSE == 1) begin : g_stb_one
         // R4
         strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel[i] && strobe_flag[i] && $past(bus_sel[i]) && $past(strong_up_en[i])
               && bus_dout[i]) |-> !strong_up_en[i]);
      end
   end

endmodule

// File: tb/test_pin_drive_oneshot.sv
module test_pin_drive_oneshot;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 4;
   localparam int IOP        = 2;
   localparam int STP        = 1;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] port_latch = '1;
   logic [NP-1:0] bus_sel = '0;
   logic [NP-1:0] bus_dout = '0;
   logic [NP-1:0] strobe_flag = 4'b1100;
   logic [NP-1:0] pull_down_en;
   logic [NP-1:0] strong_up_en;
   logic [NP-1:0] weak_up_en;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    finished = 0;
   string tag_override = "";

   int m_prev_v [NP];
   int m_prev_m [NP];
   int m_cnt    [NP];
   int m_trig   [NP];
   int m_v      [NP];
   int m_cap    [NP];

   int unsigned seed = 32'h1234_abcd;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_drive_oneshot #(.PINS(NP), .IO_PULSE(IOP), .STROBE_PULSE(STP)) i_pin_drive_oneshot (
      .clk          (clk),
      .rst_n        (rst_n),
      .port_latch   (port_latch),
      .bus_sel      (bus_sel),
      .bus_dout     (bus_dout),
      .strobe_flag  (strobe_flag),
      .pull_down_en (pull_down_en),
      .strong_up_en (strong_up_en),
      .weak_up_en   (weak_up_en)
   );

   task automatic model_reset();
      for (int p = 0; p < NP; p++) begin
         m_prev_v[p] = 1;
         m_prev_m[p] = 0;
         m_cnt[p]    = 0;
      end
   endtask

   function automatic string classify(int p, int v, int m, int s);
      if (tag_override != "") return tag_override;
      if (v == 0)             return "R5";
      if (m == 1 && s == 0)   return "R6";
      if (m == 1)             return "R4";
      if (m_prev_m[p] == 1)   return "R3";
      if (m_trig[p] != 0 || m_cnt[p] > 0) return "R1";
      return "R2";
   endfunction

   task automatic compare_now();
      for (int p = 0; p < NP; p++) begin
         int v, m, s, same, exp_spu, exp_pd, exp_wpu;
         string tg;
         m = bus_sel[p];
         s = strobe_flag[p];
         v = m ? bus_dout[p] : port_latch[p];
         same = (m == m_prev_m[p]);
         m_cap[p]  = (m == 0 || s == 1);
         m_trig[p] = (m_cap[p] && v == 1 && m_prev_v[p] == 0 && same);
         m_v[p]    = v;
         if (m_cap[p])
            exp_spu = (v == 1) && (m_trig[p] || (m_cnt[p] > 0 && same));
         else
            exp_spu = v;
         exp_pd  = (v == 0);
         exp_wpu = (v == 1);
         tg = classify(p, v, m, s);
         n_checks++;
         if (pull_down_en[p] !== exp_pd[0] || strong_up_en[p] !== exp_spu[0]
             || weak_up_en[p] !== exp_wpu[0]) begin
            n_fail++;
            $display("FAIL %s pin %0d: pd/spu/wpu actual %b%b%b expected %0d%0d%0d at %0t",
                     tg, p, pull_down_en[p], strong_up_en[p], weak_up_en[p],
                     exp_pd, exp_spu, exp_wpu, $time);
         end
         // R9: pull-down never with a pull-up
         n_checks++;
         if (pull_down_en[p] === 1'b1 && (strong_up_en[p] !== 1'b0 || weak_up_en[p] !== 1'b0)) begin
            n_fail++;
            $display("FAIL R9 pin %0d: pd/spu/wpu actual %b%b%b expected pd exclusive",
                     p, pull_down_en[p], strong_up_en[p], weak_up_en[p]);
         end
      end
   endtask

   task automatic model_advance();
      for (int p = 0; p < NP; p++) begin
         int m, same;
         m = bus_sel[p];
         same = (m == m_prev_m[p]);
         if (m_trig[p])
            m_cnt[p] = (m == 1) ? STP - 1 : IOP - 1;
         else if (m_cnt[p] > 0 && m_v[p] == 1 && same && m_cap[p])
            m_cnt[p] = m_cnt[p] - 1;
         else
            m_cnt[p] = 0;
         m_prev_v[p] = m_v[p];
         m_prev_m[p] = m;
      end
   endtask

   // inputs are already set, we are past a falling edge
   task automatic step();
      #1;
      compare_now();
      @(posedge clk);
      if (rst_n) model_advance();
      else       model_reset();
      @(negedge clk);
   endtask

   function automatic int unsigned next_rand();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      model_reset();
      @(negedge clk);
      // R8: reset state with latch high
      tag_override = "R8";
      step();
      step();
      rst_n = 1'b1;
      step();
      tag_override = "";

      // R5 then R1 / R2: latch low, then rise and hold
      port_latch = '0;
      step(); step();
      port_latch = '1;
      for (int k = 0; k < 5; k++) step();

      // R7: 1-0-1 during a burst restarts it
      port_latch = '0; step();
      tag_override = "R7";
      port_latch = '1; step();
      port_latch = '0; step();
      port_latch = '1; step(); step(); step(); step();
      tag_override = "";

      // R4 / R6: bus mode, low then rising bus value, toggles
      bus_sel = '1; bus_dout = '0;
      step(); step();
      bus_dout = '1;
      for (int k = 0; k < 3; k++) step();
      bus_dout = '0; step();
      bus_dout = '1; step(); step();

      // R3: bus low with latch 1, switch to I/O
      bus_dout = '0; port_latch = '1; step();
      tag_override = "R3";
      bus_sel = '0; step();
      tag_override = "";
      step(); step();

      // mixed pseudo-random phase on all pins
      for (int k = 0; k < 3000; k++) begin
         int unsigned r;
         r = next_rand();
         for (int p = 0; p < NP; p++) begin
            if (r[p*3 +: 2] == 2'b00) port_latch[p] = ~port_latch[p];
            if (r[p*3 + 2] && r[20 + p]) bus_dout[p] = ~bus_dout[p];
            if (r[28 +: 4] == 4'(p)) bus_sel[p] = ~bus_sel[p];
         end
         step();
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule